// File: doc/BRIEF.md
# Edge-Triggered GPIO Interrupt Bank

This block serves one bank of general-purpose pins. It holds one output register and one direction and trigger setting for each pin. It also watches the pins that are configured as inputs and turns the selected transitions into sticky pending bits. Every pin passes through a two-stage synchronizer before any edge is detected. A single bank interrupt line is raised while any pending bit is left unmasked.

Software reaches the block through a simple single-cycle register port. A write takes effect on the rising clock edge at which `req_i` and `we_i` are both high. Read data is a combinational function of `addr_i`. Each bank register is placed at its base offset plus 4×`BANK_ID`. Each per-pin control word sits at 0x100 + 4×(global pin number), where the global number is `BANK_ID`×`NUM_PINS` plus the local pin index.

The pad side is a plain output value and output-enable pair per pin, plus the raw input pins. Outputs and mask bits are changed only through dedicated set and clear addresses, so software never needs a read-modify-write.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, every pin reads as an input with trigger 0, so `pin_oe_o` is 0. `pin_o` is 0, the mask (0xA0) reads all ones, the pending status (0x80) reads 0 and `irq_o` is low.
- R2: The control word of pin p is at 0x100 + 4×p. Bit 0 is the direction (1 = input, 0 = output, and output drives `pin_oe_o[p]` high). Bits [4:3] are the trigger. All other bits read 0, and unmapped addresses read 0.
- R3: Writing 1s to 0x40 drives those outputs high. Writing 1s to 0x60 drives them low. Zero bits leave an output unchanged. The output value reads at 0x00 and appears on `pin_o`.
- R4: Offset 0x20 returns the synchronized pins: a change on `pin_i` becomes visible after the second rising clock edge.
- R5: Trigger 1 detects rising edges, trigger 2 detects falling edges and trigger 3 detects both. The pending bit becomes set on the third rising clock edge after the pin changes.
- R6: A pin with trigger 0, or a pin configured as an output, never sets its pending bit.
- R7: Writing 1s to 0x80 clears those pending bits. Zero bits leave them unchanged. With no clear, a pending bit holds.
- R8: If an edge and a clear of the same pending bit land in the same cycle, the bit ends up set.
- R9: Writing 1s to 0xA0 masks those pins and writing 1s to 0xC0 unmasks them. Zero bits have no effect. The mask reads back at 0xA0.
- R10: `irq_o` is high exactly when (status & ~mask) is nonzero, in the same cycle as the state that causes it.
- R11: An edge that arrives after a pending bit has been cleared sets that bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W (12) | Byte address |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data for `addr_i`, combinational |
| pin_i | input | NUM_PINS (32) | Raw pin inputs |
| pin_o | output | NUM_PINS (32) | Output values |
| pin_oe_o | output | NUM_PINS (32) | Output enables (1 = pin driven) |
| irq_o | output | 1 | Bank interrupt |

## Verification
A corrupt synchronizer or edge stage shows up at the ports in two ways. The pending status becomes set one cycle early or late against the fixed three-edge latency, or it is set by the wrong polarity. A reference model that advances every clock catches this on the first affected cycle. A wrong mask or pending bit reaches `irq_o` in the same cycle, because the interrupt has no register stage. A lost clear-versus-edge race shows as a status bit that reads 0 one cycle after the collision.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_BOTH = 2'd3
  } trig_e;

  typedef struct packed {
    trig_e trig;
    logic  is_in;
  } pin_cfg_t;

  localparam int CTRL_W        = 5;
  localparam int CTRL_DIR_BIT  = 0;
  localparam int CTRL_TRIG_LSB = 3;

  localparam int OFS_OUT_VAL = 'h00;
  localparam int OFS_IN_VAL  = 'h20;
  localparam int OFS_OUT_SET = 'h40;
  localparam int OFS_OUT_CLR = 'h60;
  localparam int OFS_PEND    = 'h80;
  localparam int OFS_MASK    = 'hA0;
  localparam int OFS_UNMASK  = 'hC0;
  localparam int OFS_CTRL    = 'h100;
  localparam int WORD_STRIDE = 4;

  localparam pin_cfg_t CFG_RST = '{trig: TRIG_OFF, is_in: 1'b1};

  function automatic logic [CTRL_W-1:0] cfg_pack(pin_cfg_t c);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[CTRL_DIR_BIT] = c.is_in;
    w[CTRL_TRIG_LSB +: 2] = c.trig;
    return w;
  endfunction

  function automatic pin_cfg_t cfg_unpack(logic [CTRL_W-1:0] w);
    pin_cfg_t c;
    c.is_in = w[CTRL_DIR_BIT];
    c.trig  = trig_e'(w[CTRL_TRIG_LSB +: 2]);
    return c;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] prev_o
);
  localparam int LAST = STAGES;

  // stages 0..STAGES-1 synchronize, stage STAGES holds the previous sample
  logic [N-1:0] stg_q [LAST+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k <= LAST; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= pin_i;
      for (int k = 1; k <= LAST; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign sync_o = stg_q[LAST-1];
  assign prev_o = stg_q[LAST];

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
  import gpio_bank_pkg::*;
#(
  parameter int N = 32
) (
  input  pin_cfg_t [N-1:0] cfg_i,
  input  logic     [N-1:0] sync_i,
  input  logic     [N-1:0] prev_i,
  output logic     [N-1:0] edge_o
);
  for (genvar p = 0; p < N; p++) begin : g_pin
    logic rise, fall, hit;
    assign rise = sync_i[p] & ~prev_i[p];
    assign fall = ~sync_i[p] & prev_i[p];
    always_comb begin
      unique case (cfg_i[p].trig)
        TRIG_RISE: hit = rise;
        TRIG_FALL: hit = fall;
        TRIG_BOTH: hit = rise | fall;
        default:   hit = 1'b0;
      endcase
    end
    // outputs never raise events
    assign edge_o[p] = cfg_i[p].is_in & hit;
  end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | set_i;
  end

  assign status_o = status_q;

  AST_EDGE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i))); // R8

  AST_HOLD_WITHOUT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((status_q & $past(status_q)) == $past(status_q))); // R7

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int N       = 32,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int BANK_ID = 0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [N-1:0]          in_sync_i,
  input  logic [N-1:0]          status_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [N-1:0]          out_o,
  output pin_cfg_t [N-1:0]      cfg_o,
  output logic [N-1:0]          mask_o,
  output logic [N-1:0]          pend_clr_o
);
  localparam int BANK_OFS = WORD_STRIDE * BANK_ID;
  localparam int PIN_BASE = BANK_ID * N;

  localparam logic [ADDR_W-1:0] A_OUT_VAL = ADDR_W'(OFS_OUT_VAL + BANK_OFS);
  localparam logic [ADDR_W-1:0] A_IN_VAL  = ADDR_W'(OFS_IN_VAL  + BANK_OFS);
  localparam logic [ADDR_W-1:0] A_OUT_SET = ADDR_W'(OFS_OUT_SET + BANK_OFS);
  localparam logic [ADDR_W-1:0] A_OUT_CLR = ADDR_W'(OFS_OUT_CLR + BANK_OFS);
  localparam logic [ADDR_W-1:0] A_PEND    = ADDR_W'(OFS_PEND    + BANK_OFS);
  localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(OFS_MASK    + BANK_OFS);
  localparam logic [ADDR_W-1:0] A_UNMASK  = ADDR_W'(OFS_UNMASK  + BANK_OFS);

  logic wr;
  logic hit_out, hit_in, hit_set, hit_clr, hit_pend, hit_mask, hit_unmask;
  logic [N-1:0] hit_ctl;
  logic [N-1:0] wbits;

  logic [N-1:0]     out_q;
  logic [N-1:0]     mask_q;
  pin_cfg_t [N-1:0] cfg_q;

  assign wr    = req_i & we_i;
  assign wbits = wdata_i[N-1:0];

  assign hit_out    = (addr_i == A_OUT_VAL);
  assign hit_in     = (addr_i == A_IN_VAL);
  assign hit_set    = (addr_i == A_OUT_SET);
  assign hit_clr    = (addr_i == A_OUT_CLR);
  assign hit_pend   = (addr_i == A_PEND);
  assign hit_mask   = (addr_i == A_MASK);
  assign hit_unmask = (addr_i == A_UNMASK);

  for (genvar p = 0; p < N; p++) begin : g_ctl_dec
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTRL + WORD_STRIDE * (PIN_BASE + p));
    assign hit_ctl[p] = (addr_i == A_CTL);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
    end else if (wr && hit_set) begin
      out_q <= out_q | wbits;
    end else if (wr && hit_clr) begin
      out_q <= out_q & ~wbits;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
    end else if (wr && hit_mask) begin
      mask_q <= mask_q | wbits;
    end else if (wr && hit_unmask) begin
      mask_q <= mask_q & ~wbits;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < N; p++) cfg_q[p] <= CFG_RST;
    end else if (wr) begin
      for (int p = 0; p < N; p++)
        if (hit_ctl[p]) cfg_q[p] <= cfg_unpack(wdata_i[CTRL_W-1:0]);
    end
  end

  assign pend_clr_o = (wr && hit_pend) ? wbits : '0;

  always_comb begin
    rdata_o = '0;
    if (hit_out)  rdata_o[N-1:0] = out_q;
    if (hit_in)   rdata_o[N-1:0] = in_sync_i;
    if (hit_pend) rdata_o[N-1:0] = status_i;
    if (hit_mask) rdata_o[N-1:0] = mask_q;
    for (int p = 0; p < N; p++)
      if (hit_ctl[p]) rdata_o[CTRL_W-1:0] = cfg_pack(cfg_q[p]);
  end

  assign out_o  = out_q;
  assign cfg_o  = cfg_q;
  assign mask_o = mask_q;

  AST_SET_DRIVES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && hit_set) |=> ((out_q & $past(wbits)) == $past(wbits))); // R3

  AST_CLR_DRIVES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && hit_clr) |=> ((out_q & $past(wbits)) == '0)); // R3

  AST_UNMASK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && hit_unmask) |=> ((mask_q & $past(wbits)) == '0)); // R9

  AST_MASK_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && hit_mask) |=> ((mask_q & $past(wbits)) == $past(wbits))); // R9

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int BANK_ID     = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0]     sync_w, prev_w, edge_w;
  logic [NUM_PINS-1:0]     status_w, mask_w, clr_w;
  pin_cfg_t [NUM_PINS-1:0] cfg_w;

  gpio_in_sync #(.N(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .sync_o (sync_w),
    .prev_o (prev_w)
  );

  gpio_edge_detect #(.N(NUM_PINS)) u_edge (
    .cfg_i  (cfg_w),
    .sync_i (sync_w),
    .prev_i (prev_w),
    .edge_o (edge_w)
  );

  gpio_irq_status #(.N(NUM_PINS)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (edge_w),
    .clr_i    (clr_w),
    .status_o (status_w)
  );

  gpio_bank_regs #(
    .N(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_ID(BANK_ID)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .in_sync_i  (sync_w),
    .status_i   (status_w),
    .rdata_o    (rdata_o),
    .out_o      (pin_o),
    .cfg_o      (cfg_w),
    .mask_o     (mask_w),
    .pend_clr_o (clr_w)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
    assign pin_oe_o[p] = ~cfg_w[p].is_in;
  end

  assign irq_o = |(status_w & ~mask_w);

  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_w != '0)); // R10

  AST_FULL_MASK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_w == '1) |-> !irq_o); // R10

endmodule

// File: tb/gpio_edge_bank_bench.sv
`timescale 1ns/1ps
module gpio_edge_bank_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [31:0] pin_i = '0;
  logic [31:0] pin_o, pin_oe_o;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  gpio_edge_bank u_gpio_edge_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] m_out = '0, m_mask = '1, m_stat = '0;
  bit          m_dir [32];
  int          m_trig [32];
  logic [31:0] hist [$] = '{32'h0, 32'h0, 32'h0};

  initial for (int i = 0; i < 32; i++) begin m_dir[i] = 1'b1; m_trig[i] = 0; end

  function automatic logic [31:0] m_read(input logic [11:0] a);
    logic [31:0] r;
    r = '0;
    case (a)
      12'h000: r = m_out;
      12'h020: r = hist[1];
      12'h080: r = m_stat;
      12'h0A0: r = m_mask;
      default: begin
        for (int i = 0; i < 32; i++)
          if (a == 12'h100 + 12'(4 * i)) r = {27'd0, 2'(m_trig[i]), 2'b00, m_dir[i]};
      end
    endcase
    return r;
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_out = '0; m_mask = '1; m_stat = '0;
      for (int i = 0; i < 32; i++) begin m_dir[i] = 1'b1; m_trig[i] = 0; end
      hist = '{32'h0, 32'h0, 32'h0};
    end else begin
      logic [31:0] ev, clr;
      ev = '0; clr = '0;
      for (int i = 0; i < 32; i++) begin
        bit now_v, old_v;
        now_v = hist[1][i]; old_v = hist[2][i];
        if (m_dir[i] && (((m_trig[i] % 2) == 1 && now_v && !old_v) ||
                         (m_trig[i] >= 2 && !now_v && old_v))) ev[i] = 1'b1;
      end
      if (req_i && we_i) begin
        case (addr_i)
          12'h040: m_out  = m_out | wdata_i;
          12'h060: m_out  = m_out & ~wdata_i;
          12'h080: clr    = wdata_i;
          12'h0A0: m_mask = m_mask | wdata_i;
          12'h0C0: m_mask = m_mask & ~wdata_i;
          default: begin
            for (int i = 0; i < 32; i++)
              if (addr_i == 12'h100 + 12'(4 * i)) begin
                m_dir[i] = wdata_i[0]; m_trig[i] = int'(wdata_i[4:3]);
              end
          end
        endcase
      end
      m_stat = (m_stat & ~clr) | ev;
      hist.push_front(pin_i);
      void'(hist.pop_back());
    end
    #2;
    if (rst_ni) begin
      logic [31:0] oe;
      for (int i = 0; i < 32; i++) oe[i] = !m_dir[i];
      chk("R10 irq model", {31'd0, irq_o}, {31'd0, |(m_stat & ~m_mask)});
      chk("R3 pin_o model", pin_o, m_out);
      chk("R2 pin_oe model", pin_oe_o, oe);
      chk("R4/R7/R9 rdata model", rdata_o, m_read(addr_i));
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd_now(input logic [11:0] a, output logic [31:0] d);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1;
    d = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst_ni = 1'b1;
    idle(1);

    // R1 reset state
    rd_now(12'h114, d); chk("R1 ctrl pin5 reset", d, 32'h1);
    rd_now(12'h0A0, d); chk("R1 mask reset", d, 32'hFFFF_FFFF);
    rd_now(12'h080, d); chk("R1 status reset", d, 32'h0);
    chk("R1 irq reset", {31'd0, irq_o}, 32'h0);
    chk("R1 oe reset", pin_oe_o, 32'h0);
    chk("R1 pin_o reset", pin_o, 32'h0);

    // R2 control word
    wr(12'h10C, 32'h0);
    chk("R2 pin3 output enables", pin_oe_o, 32'h8);
    rd_now(12'h10C, d); chk("R2 ctrl pin3 readback", d, 32'h0);
    wr(12'h11C, 32'hFFFF_FFFF);
    rd_now(12'h11C, d); chk("R2 ctrl unused bits zero", d, 32'h19);
    rd_now(12'h004, d); chk("R2 unmapped reads zero", d, 32'h0);

    // R3 set / clear outputs
    wr(12'h040, 32'h88);
    chk("R3 set drives pins", pin_o, 32'h88);
    wr(12'h060, 32'h08);
    rd_now(12'h000, d); chk("R3 clear drives low", d, 32'h80);
    wr(12'h040, 32'h0);
    chk("R3 zero set no effect", pin_o, 32'h80);

    // R4 synchronized input latency
    @(negedge clk_i); pin_i = 32'hA5;
    @(negedge clk_i); rd_now(12'h020, d); chk("R4 not yet visible", d, 32'h0);
    @(negedge clk_i); rd_now(12'h020, d); chk("R4 visible after two edges", d, 32'hA5);
    pin_i = 32'h0;
    idle(5);
    wr(12'h080, 32'hFFFF_FFFF);

    // R5 edge selection and latency
    wr(12'h100, 32'h09);
    wr(12'h104, 32'h11);
    wr(12'h108, 32'h19);
    wr(12'h0C0, 32'h7);
    @(negedge clk_i); pin_i = 32'h7;
    @(negedge clk_i);
    @(negedge clk_i); rd_now(12'h080, d); chk("R5 pending not yet", d, 32'h0);
    @(negedge clk_i); rd_now(12'h080, d); chk("R5 rising and both", d, 32'h5);
    chk("R10 irq raised", {31'd0, irq_o}, 32'h1);
    wr(12'h080, 32'h5);
    rd_now(12'h080, d); chk("R7 w1c clears", d, 32'h0);
    chk("R10 irq dropped", {31'd0, irq_o}, 32'h0);
    @(negedge clk_i); pin_i = 32'h0;
    idle(3);
    rd_now(12'h080, d); chk("R11 falling and both after clear", d, 32'h6);

    // R6 disabled trigger and output pin
    wr(12'h10C, 32'h18);
    @(negedge clk_i); pin_i = 32'h18;
    idle(4);
    rd_now(12'h080, d); chk("R6 no event on rise", d, 32'h6);
    @(negedge clk_i); pin_i = 32'h0;
    idle(4);
    rd_now(12'h080, d); chk("R6 no event on fall", d, 32'h6);

    // R7 partial clear and zero write
    wr(12'h080, 32'h2);
    rd_now(12'h080, d); chk("R7 partial clear", d, 32'h4);
    wr(12'h080, 32'h0);
    rd_now(12'h080, d); chk("R7 zero write holds", d, 32'h4);
    wr(12'h080, 32'hFFFF_FFFF);
    idle(2);

    // R8 edge and clear collide
    @(negedge clk_i); pin_i = 32'h1;
    @(negedge clk_i);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = 12'h080; wdata_i = 32'h1;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    rd_now(12'h080, d); chk("R8 edge wins over clear", d, 32'h1);
    chk("R10 irq on collision bit", {31'd0, irq_o}, 32'h1);

    // R9 mask set / clear
    rd_now(12'h0A0, d); chk("R9 mask after unmask", d, 32'hFFFF_FFF8);
    wr(12'h0A0, 32'h1);
    rd_now(12'h0A0, d); chk("R9 mask set", d, 32'hFFFF_FFF9);
    chk("R10 masked pending quiet", {31'd0, irq_o}, 32'h0);
    wr(12'h0C0, 32'h0);
    rd_now(12'h0A0, d); chk("R9 zero unmask no effect", d, 32'hFFFF_FFF9);
    wr(12'h0C0, 32'h1);
    chk("R10 unmask raises irq", {31'd0, irq_o}, 32'h1);

    idle(2);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule